// File: doc/BRIEF.md
# Dual-Sided Mailbox Message Unit

The block lets two processors trade 32-bit words without shared memory. Each side sees its own small register window: four send registers, four receive registers, a status word and a control word. A word written into send register n on one side appears in receive register n on the other side. Two flags track each channel. The sender's empty flag drops when the word is written. The receiver's full flag rises at the same time. When the receiver reads the word, both flags return to their idle values. This makes each channel a one-deep, one-way queue.

Each side also gets four doorbell bits. A side raises a doorbell in its control word. The peer sees it as a pending bit in its status word and acknowledges it by writing 1 to that bit, which also drops the doorbell. Each side drives one interrupt line. The line is the OR of its enabled empty, full and pending conditions.

The register bus on each side never applies back-pressure. A request is taken in the cycle where `req` is high. A read request returns `rdata` with `rvalid` high in the following cycle. A write takes effect at that same clock edge.

Top module: `mbox_unit`

## Requirements
- R1: After reset, every transmit-empty flag is 1, every receive-full and pending flag is 0, the control word is 0, both interrupt lines are low and both `rvalid` outputs are low.
- R2: Word addresses are 0 to 3 for send registers 0 to 3, 4 to 7 for receive registers 0 to 3, 8 for status and 9 for control. A word written to send register n on one side is returned by a read of receive register n on the other side.
- R3: In the status word, channel n places its transmit-empty flag at bit 23-n, its receive-full flag at bit 27-n and its pending flag at bit 31-n. All other bits read 0. Writing send register n clears the writer's empty flag n and sets the peer's full flag n.
- R4: A write to a send register whose channel is still full is ignored. The stored word and the flags stay unchanged.
- R5: Reading receive register n while it is full clears that side's full flag n and sets the peer's empty flag n. Reading it while it is empty returns the last word held and changes no flag.
- R6: Writes to receive registers have no effect. Status bits other than the pending bits ignore writes.
- R7: In the control word, channel n places its pending-interrupt enable at bit 31-n, its full-interrupt enable at bit 27-n, its empty-interrupt enable at bit 23-n and its doorbell request at bit 19-n. Bit 3 is a non-maskable request flag and bits 2:0 are user flags. Only the bits in mask 0xFFFF000F are stored; all other bits read 0. Writing 0 clears every field.
- R8: Doorbell request n set on one side shows as pending bit n on the peer. When the peer writes 1 to that pending bit, the pending bit clears and so does the request. If the requesting side writes its control word in the same cycle, that write takes priority.
- R9: A side's interrupt is high exactly when some channel has an enabled pending, full or empty condition on that side.
- R10: A read request produces `rvalid` high with its data in the next cycle. `rvalid` is low in every cycle after a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Side A bus request, always accepted |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid with a_rvalid |
| a_rvalid | output | 1 | Side A read response strobe |
| a_irq | output | 1 | Side A interrupt |
| b_req | input | 1 | Side B bus request, always accepted |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid with b_rvalid |
| b_rvalid | output | 1 | Side B read response strobe |
| b_irq | output | 1 | Side B interrupt |

## Verification
The properties assume that `req`, `we` and `addr` on each side are driven to defined values in every cycle after reset. They also assume that a full flag can only drop when that channel's receive register is read. The stimulus drives each side only through one-cycle requests at decoded addresses, and it holds `req` low between operations. It also writes a full channel on purpose, to show that such a write is dropped rather than relying on software to keep the handshake.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NCH       = 4;
  localparam int TX_BASE   = 0;
  localparam int RX_BASE   = 4;
  localparam int STAT_ADDR = 8;
  localparam int CTRL_ADDR = 9;
  // top bit of each per-channel field; channel n sits at (top - n)
  localparam int PEND_TOP  = 31;
  localparam int FULL_TOP  = 27;
  localparam int EMPTY_TOP = 23;
  localparam int BELL_TOP  = 19;
  localparam int NMI_BIT   = 3;
  localparam int UFLAG_W   = 3;
endpackage

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en && !full) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (rd_en) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_ctrl_reg.sv
module mbox_ctrl_reg
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    bell_clr,
  output logic [NCH-1:0]    pend_en,
  output logic [NCH-1:0]    full_en,
  output logic [NCH-1:0]    empty_en,
  output logic [NCH-1:0]    bell,
  output logic [DATA_W-1:0] word
);
  logic               nmi_q;
  logic [UFLAG_W-1:0] uflag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_en  <= '0;
      full_en  <= '0;
      empty_en <= '0;
      bell     <= '0;
      nmi_q    <= 1'b0;
      uflag_q  <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NCH; n++) begin
        pend_en[n]  <= wr_data[PEND_TOP - n];
        full_en[n]  <= wr_data[FULL_TOP - n];
        empty_en[n] <= wr_data[EMPTY_TOP - n];
        bell[n]     <= wr_data[BELL_TOP - n];
      end
      nmi_q   <= wr_data[NMI_BIT];
      uflag_q <= wr_data[UFLAG_W-1:0];
    end else begin
      bell <= bell & ~bell_clr;
    end
  end

  always_comb begin
    word = '0;
    for (int n = 0; n < NCH; n++) begin
      word[PEND_TOP - n]  = pend_en[n];
      word[FULL_TOP - n]  = full_en[n];
      word[EMPTY_TOP - n] = empty_en[n];
      word[BELL_TOP - n]  = bell[n];
    end
    word[NMI_BIT]       = nmi_q;
    word[UFLAG_W-1:0]   = uflag_q;
  end
endmodule

// File: rtl/mbox_side.sv
module mbox_side
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq,
  output logic [NCH-1:0]    tx_wr,
  input  logic [NCH-1:0]    tx_full,
  output logic [NCH-1:0]    rx_rd,
  input  logic [NCH-1:0]    rx_full,
  input  logic [DATA_W-1:0] rx_data [NCH],
  input  logic [NCH-1:0]    peer_bell,
  output logic [NCH-1:0]    pend_clr,
  input  logic [NCH-1:0]    own_bell_clr,
  output logic [NCH-1:0]    own_bell
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  logic              wr_cyc, rd_cyc, ctrl_wr;
  logic [NCH-1:0]    pend_en, full_en, empty_en, empty;
  logic [DATA_W-1:0] ctrl_word, stat_word, rd_mux;

  assign wr_cyc  = req && we;
  assign rd_cyc  = req && !we;
  assign ctrl_wr = wr_cyc && (addr == A_CTRL);
  assign empty   = ~tx_full;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign tx_wr[n]    = wr_cyc && (addr == ADDR_W'(TX_BASE + n));
    assign rx_rd[n]    = rd_cyc && (addr == ADDR_W'(RX_BASE + n));
    assign pend_clr[n] = wr_cyc && (addr == A_STAT) && wdata[PEND_TOP - n];
  end

  mbox_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wr_data  (wdata),
    .bell_clr (own_bell_clr),
    .pend_en  (pend_en),
    .full_en  (full_en),
    .empty_en (empty_en),
    .bell     (own_bell),
    .word     (ctrl_word)
  );

  always_comb begin
    stat_word = '0;
    for (int n = 0; n < NCH; n++) begin
      stat_word[PEND_TOP - n]  = peer_bell[n];
      stat_word[FULL_TOP - n]  = rx_full[n];
      stat_word[EMPTY_TOP - n] = empty[n];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_STAT) rd_mux = stat_word;
    else if (addr == A_CTRL) rd_mux = ctrl_word;
    else begin
      for (int n = 0; n < NCH; n++)
        if (addr == ADDR_W'(RX_BASE + n)) rd_mux = rx_data[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_cyc;
      if (rd_cyc) rdata <= rd_mux;
    end
  end

  assign irq = |(pend_en & peer_bell) | |(full_en & rx_full) | |(empty_en & empty);
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              a_irq,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              b_irq
);
  logic [NCH-1:0]    a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NCH-1:0]    a2b_full, b2a_full;
  logic [DATA_W-1:0] a2b_data [NCH];
  logic [DATA_W-1:0] b2a_data [NCH];
  logic [NCH-1:0]    a_bell, b_bell, a_pend_clr, b_pend_clr;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mbox_channel #(.DATA_W(DATA_W)) u_a2b (
      .clk(clk), .rst_n(rst_n),
      .wr_en(a_tx_wr[n]), .wr_data(a_wdata), .rd_en(b_rx_rd[n]),
      .full(a2b_full[n]), .data(a2b_data[n])
    );
    mbox_channel #(.DATA_W(DATA_W)) u_b2a (
      .clk(clk), .rst_n(rst_n),
      .wr_en(b_tx_wr[n]), .wr_data(b_wdata), .rd_en(a_rx_rd[n]),
      .full(b2a_full[n]), .data(b2a_data[n])
    );
  end

  mbox_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_a (
    .clk(clk), .rst_n(rst_n),
    .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .rvalid(a_rvalid), .irq(a_irq),
    .tx_wr(a_tx_wr), .tx_full(a2b_full),
    .rx_rd(a_rx_rd), .rx_full(b2a_full), .rx_data(b2a_data),
    .peer_bell(b_bell), .pend_clr(a_pend_clr),
    .own_bell_clr(b_pend_clr), .own_bell(a_bell)
  );

  mbox_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_b (
    .clk(clk), .rst_n(rst_n),
    .req(b_req), .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .rvalid(b_rvalid), .irq(b_irq),
    .tx_wr(b_tx_wr), .tx_full(b2a_full),
    .rx_rd(b_rx_rd), .rx_full(a2b_full), .rx_data(a2b_data),
    .peer_bell(a_bell), .pend_clr(b_pend_clr),
    .own_bell_clr(a_pend_clr), .own_bell(b_bell)
  );
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_req,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [31:0]       b_wdata,
  input logic              a_rvalid,
  input logic              b_req,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [NCH-1:0]    a2b_full,
  input logic [NCH-1:0]    a_bell
);
  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_we) |=> a_rvalid);
  assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_req && !a_we) |=> !a_rvalid);

  for (genvar n = 0; n < NCH; n++) begin : g_p
    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && a_we && a_addr == ADDR_W'(TX_BASE + n)) |=> a2b_full[n]);
    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (a2b_full[n] && !(b_req && !b_we && b_addr == ADDR_W'(RX_BASE + n))) |=> a2b_full[n]);
    assert_read_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_req && !b_we && b_addr == ADDR_W'(RX_BASE + n)) |=> !a2b_full[n]);
    assert_ack_drops_bell_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b_req && b_we && b_addr == ADDR_W'(STAT_ADDR) && b_wdata[PEND_TOP - n]
       && !(a_req && a_we && a_addr == ADDR_W'(CTRL_ADDR))) |=> !a_bell[n]);
  end
endmodule

bind mbox_unit mbox_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .b_wdata(b_wdata),
  .a_rvalid(a_rvalid),
  .b_req(b_req), .b_we(b_we), .b_addr(b_addr),
  .a2b_full(a2b_full), .a_bell(a_bell)
);

// File: tb/mbox_unit_tb.sv
module mbox_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, a_irq, b_irq;
  int checks = 0, failures = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  mbox_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_irq(b_irq)
  );

  // {req_tag[74:71], side[70], we[69], addr[68:65], wdata[64:33], expect[32:1], check[0]}
  localparam int NV = 35;
  localparam logic [74:0] VEC [NV] = '{
    {4'd1, 1'b0,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R1 idle status
    {4'd2, 1'b0,1'b1,4'd0, 32'h11111111, 32'h0,       1'b0},
    {4'd3, 1'b0,1'b0,4'd8, 32'h0,        32'h00700000,1'b1}, // R3 empty0 drops
    {4'd3, 1'b1,1'b0,4'd8, 32'h0,        32'h08F00000,1'b1}, // R3 full0 at bit27
    {4'd2, 1'b1,1'b0,4'd4, 32'h0,        32'h11111111,1'b1}, // R2 data crosses
    {4'd5, 1'b1,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R5
    {4'd5, 1'b0,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R5
    {4'd2, 1'b0,1'b1,4'd2, 32'hCAFEF00D, 32'h0,       1'b0},
    {4'd2, 1'b0,1'b1,4'd3, 32'h0BADBEEF, 32'h0,       1'b0},
    {4'd3, 1'b1,1'b0,4'd8, 32'h0,        32'h03F00000,1'b1}, // R3
    {4'd2, 1'b1,1'b0,4'd7, 32'h0,        32'h0BADBEEF,1'b1}, // R2
    {4'd2, 1'b1,1'b0,4'd6, 32'h0,        32'hCAFEF00D,1'b1}, // R2
    {4'd2, 1'b1,1'b1,4'd1, 32'h12345678, 32'h0,       1'b0},
    {4'd3, 1'b0,1'b0,4'd8, 32'h0,        32'h04F00000,1'b1}, // R3
    {4'd2, 1'b0,1'b0,4'd5, 32'h0,        32'h12345678,1'b1}, // R2
    {4'd6, 1'b0,1'b1,4'd4, 32'hFFFFFFFF, 32'h0,       1'b0},
    {4'd6, 1'b0,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R6
    {4'd6, 1'b1,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R6
    {4'd6, 1'b0,1'b1,4'd8, 32'hFFFFFFFF, 32'h0,       1'b0},
    {4'd6, 1'b0,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R6
    {4'd8, 1'b0,1'b1,4'd9, 32'h00080000, 32'h0,       1'b0},
    {4'd8, 1'b1,1'b0,4'd8, 32'h0,        32'h80F00000,1'b1}, // R8 pending0
    {4'd7, 1'b0,1'b0,4'd9, 32'h0,        32'h00080000,1'b1}, // R7
    {4'd8, 1'b1,1'b1,4'd8, 32'h80000000, 32'h0,       1'b0},
    {4'd8, 1'b1,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R8
    {4'd8, 1'b0,1'b0,4'd9, 32'h0,        32'h00000000,1'b1}, // R8 request gone
    {4'd7, 1'b0,1'b1,4'd9, 32'hFFFFFFFF, 32'h0,       1'b0},
    {4'd7, 1'b0,1'b0,4'd9, 32'h0,        32'hFFFF000F,1'b1}, // R7 mask
    {4'd8, 1'b1,1'b0,4'd8, 32'h0,        32'hF0F00000,1'b1}, // R8
    {4'd7, 1'b0,1'b1,4'd9, 32'h0,        32'h0,       1'b0},
    {4'd7, 1'b0,1'b0,4'd9, 32'h0,        32'h0,       1'b1}, // R7 clear
    {4'd8, 1'b1,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R8
    {4'd5, 1'b1,1'b0,4'd4, 32'h0,        32'h11111111,1'b1}, // R5 stale word
    {4'd5, 1'b1,1'b0,4'd8, 32'h0,        32'h00F00000,1'b1}, // R5 no flag change
    {4'd6, 1'b0,1'b0,4'd4, 32'h0,        32'h00000000,1'b1}  // R6 rx write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus operation; response sampled at the following falling edge
  task automatic op(input logic side, input logic we, input logic [3:0] addr,
                    input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    if (!side) begin a_req = 1; a_we = we; a_addr = addr; a_wdata = wd; end
    else       begin b_req = 1; b_we = we; b_addr = addr; b_wdata = wd; end
    @(negedge clk);
    a_req = 0; b_req = 0;
    if (!we) begin
      rd = side ? b_rdata : a_rdata;
      check("R10 rvalid", {31'b0, side ? b_rvalid : a_rvalid}, 32'd1);
    end else rd = '0;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the pins
    check("R1 a_irq", {31'b0, a_irq}, 32'd0);
    check("R1 b_irq", {31'b0, b_irq}, 32'd0);
    check("R1 a_rvalid", {31'b0, a_rvalid}, 32'd0);
    op(1'b1, 1'b0, 4'd9, 32'h0, got);
    check("R1 b ctrl", got, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][70], VEC[i][69], VEC[i][68:65], VEC[i][64:33], got);
      if (VEC[i][0]) check($sformatf("R%0d vector %0d", VEC[i][74:71], i), got, VEC[i][32:1]);
    end

    // R4 write into a full channel is dropped
    op(1'b0, 1'b1, 4'd0, 32'hAAAAAAAA, got);
    op(1'b0, 1'b1, 4'd0, 32'h55555555, got);
    op(1'b1, 1'b0, 4'd4, 32'h0, got);
    check("R4 first word kept", got, 32'hAAAAAAAA);
    op(1'b0, 1'b0, 4'd8, 32'h0, got);
    check("R4 flags back to idle", got, 32'h00F00000);

    // R9 full-interrupt on side B, channel 0 (enable bit 27)
    op(1'b1, 1'b1, 4'd9, 32'h08000000, got);
    check("R9 b_irq idle", {31'b0, b_irq}, 32'd0);
    op(1'b0, 1'b1, 4'd0, 32'h00000042, got);
    check("R9 b_irq on full", {31'b0, b_irq}, 32'd1);
    op(1'b1, 1'b0, 4'd4, 32'h0, got);
    check("R9 b_irq after read", {31'b0, b_irq}, 32'd0);

    // R9 empty-interrupt on side A, channel 1 (enable bit 22)
    op(1'b0, 1'b1, 4'd9, 32'h00400000, got);
    check("R9 a_irq empty", {31'b0, a_irq}, 32'd1);
    op(1'b0, 1'b1, 4'd1, 32'h00000007, got);
    check("R9 a_irq sent", {31'b0, a_irq}, 32'd0);
    op(1'b1, 1'b0, 4'd5, 32'h0, got);
    check("R9 a_irq drained", {31'b0, a_irq}, 32'd1);

    // R8 / R9 doorbell 2: B enables pending2 (bit 29), A rings (bit 17)
    op(1'b1, 1'b1, 4'd9, 32'h20000000, got);
    op(1'b0, 1'b1, 4'd9, 32'h00020000, got);
    check("R9 b_irq doorbell", {31'b0, b_irq}, 32'd1);
    op(1'b1, 1'b1, 4'd8, 32'h20000000, got);
    check("R8 b_irq after ack", {31'b0, b_irq}, 32'd0);
    op(1'b0, 1'b0, 4'd9, 32'h0, got);
    check("R8 request cleared", got, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule